// File: doc/BRIEF.md
# Key-Sequence Configuration Write Guard

This block sits in front of the writable setup registers of an embedded flash controller and keeps stray software writes away from them. The registers it holds are the read-side setup (wait-state count, cache enable, cache reset, low-power read select), the program/erase setup (program/erase enable, operation mode, bus-hold control) and the two bounds of the protect window. Their fields drive the rest of the controller through dedicated outputs.

Software opens the guard by writing two 16-bit keys in order to a dedicated key register: first 0x0123, then directly 0x3210. Once open, the guarded registers accept writes. Any later write to the key register shuts the guard again, so writing 0x3210 twice is the usual way to close it. Reading the key register returns only the open/closed state. While the guard is closed, writes to guarded registers are dropped and a sticky write-protect error bit is raised. Software clears that bit through a status register that is never guarded.

Top module: `flash_cfg_guard`

## Requirements
- R1: After reset the guard is closed with no key pending, every guarded field reads 0 and the write-protect error bit is 0.
- R2: A key-register write whose low 16 bits are 0x0123, followed by the next key-register write with low 16 bits 0x3210, opens the guard. `unlocked` is high from the cycle after the second write.
- R3: A read of the key register (address 0) returns 0x00000001 while open and 0x00000000 while closed.
- R4: While open, any write to the key register closes the guard, so two writes of 0x3210 in a row leave it closed.
- R5: With the first key pending, a key-register write of any value other than 0x3210 clears the pending key. This includes 0x0123 itself, so a following 0x3210 does not open the guard.
- R6: A write of 0x0123 while open closes the guard and leaves the first key pending, so a following 0x3210 reopens it.
- R7: Writes to other addresses and reads between the two keys do not clear the pending first key.
- R8: Only bits [15:0] of a key-register write are compared, and the upper bits are ignored.
- R9: A write to a guarded register (addresses 1 to 4) while closed changes no guarded field and sets the write-protect error bit.
- R10: A write to a guarded register while open updates it. The new value reads back on the next cycle and appears on the field outputs.
- R11: The write-protect error bit is bit 0 of the status register (address 5). It stays set until a status write with bit 0 high clears it, and status writes are accepted whether the guard is open or closed.
- R12: Field layout. Address 1 holds wait states in [3:0], cache enable in [4], cache reset in [5] and low-power read in [6]. Address 2 holds program/erase enable in [0], mode in [3:1] and bus hold in [4]. Addresses 3 and 4 hold the 20-bit window start and end in [19:0]. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| unlocked | output | 1 | High while guarded writes are accepted |
| wp_err | output | 1 | Sticky write-protect error |
| cfg_wait | output | 4 | Flash wait-state count |
| cfg_cache_en | output | 1 | Cache enable |
| cfg_cache_rst | output | 1 | Cache reset |
| cfg_lp_read | output | 1 | Low-power read select |
| cfg_pe_en | output | 1 | Program/erase enable |
| cfg_pe_mode | output | 3 | Program/erase operation mode |
| cfg_bus_hold | output | 1 | Bus-hold control during program/erase |
| cfg_win_lo | output | 20 | Protect window start |
| cfg_win_hi | output | 20 | Protect window end |

## Verification
A wrong key-tracker state is not visible until the next key-register write. A tracker that should have cleared its pending key opens the guard one cycle after a lone 0x3210. One that lost its pending key keeps `unlocked` low after a correct pair. For this reason the stimulus mixes key writes with interleaved guarded and status writes, and it reads the key register after every operation. A wrong open/closed decision for a guarded write shows up in the very next cycle: either the field changes or `wp_err` fails to rise.

// File: rtl/flash_cfg_guard.sv
module flash_cfg_guard #(
  parameter int          ADDR_W = 4,
  parameter int          DATA_W = 32,
  parameter int          WAIT_W = 4,
  parameter int          MODE_W = 3,
  parameter int          WIN_W  = 20,
  parameter logic [15:0] KEY_A  = 16'h0123,
  parameter logic [15:0] KEY_B  = 16'h3210
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              unlocked,
  output logic              wp_err,
  output logic [WAIT_W-1:0] cfg_wait,
  output logic              cfg_cache_en,
  output logic              cfg_cache_rst,
  output logic              cfg_lp_read,
  output logic              cfg_pe_en,
  output logic [MODE_W-1:0] cfg_pe_mode,
  output logic              cfg_bus_hold,
  output logic [WIN_W-1:0]  cfg_win_lo,
  output logic [WIN_W-1:0]  cfg_win_hi
);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RD   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PGM  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_WLO  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_WHI  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5);
  localparam int RD_W  = WAIT_W + 3;
  localparam int PGM_W = MODE_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_OPEN} gstate_t;
  gstate_t st, st_nxt;

  logic [15:0] key_lo;
  logic key_wr, guarded, g_wr, stat_wr;

  assign key_lo   = bus_wdata[15:0];
  assign key_wr   = bus_we && (bus_addr == A_KEY);
  assign guarded  = (bus_addr == A_RD) || (bus_addr == A_PGM) ||
                    (bus_addr == A_WLO) || (bus_addr == A_WHI);
  assign g_wr     = bus_we && guarded;
  assign stat_wr  = bus_we && (bus_addr == A_STAT);
  assign unlocked = (st == S_OPEN);

  always_comb begin
    st_nxt = st;
    if (key_wr) begin
      case (st)
        S_ARMED: st_nxt = (key_lo == KEY_B) ? S_OPEN : S_IDLE;
        default: st_nxt = (key_lo == KEY_A) ? S_ARMED : S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_wait      <= '0;
      cfg_cache_en  <= 1'b0;
      cfg_cache_rst <= 1'b0;
      cfg_lp_read   <= 1'b0;
      cfg_pe_en     <= 1'b0;
      cfg_pe_mode   <= '0;
      cfg_bus_hold  <= 1'b0;
      cfg_win_lo    <= '0;
      cfg_win_hi    <= '0;
    end else if (g_wr && unlocked) begin
      case (bus_addr)
        A_RD: begin
          cfg_wait      <= bus_wdata[WAIT_W-1:0];
          cfg_cache_en  <= bus_wdata[WAIT_W];
          cfg_cache_rst <= bus_wdata[WAIT_W+1];
          cfg_lp_read   <= bus_wdata[WAIT_W+2];
        end
        A_PGM: begin
          cfg_pe_en    <= bus_wdata[0];
          cfg_pe_mode  <= bus_wdata[MODE_W:1];
          cfg_bus_hold <= bus_wdata[MODE_W+1];
        end
        A_WLO:   cfg_win_lo <= bus_wdata[WIN_W-1:0];
        A_WHI:   cfg_win_hi <= bus_wdata[WIN_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       wp_err <= 1'b0;
    else if (stat_wr && bus_wdata[0]) wp_err <= 1'b0;
    else if (g_wr && !unlocked)       wp_err <= 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_KEY:  bus_rdata[0] = unlocked;
      A_RD:   bus_rdata[RD_W-1:0] = {cfg_lp_read, cfg_cache_rst, cfg_cache_en, cfg_wait};
      A_PGM:  bus_rdata[PGM_W-1:0] = {cfg_bus_hold, cfg_pe_mode, cfg_pe_en};
      A_WLO:  bus_rdata[WIN_W-1:0] = cfg_win_lo;
      A_WHI:  bus_rdata[WIN_W-1:0] = cfg_win_hi;
      A_STAT: bus_rdata[0] = wp_err;
      default: ;
    endcase
  end

  logic [RD_W+PGM_W+2*WIN_W-1:0] cfg_all;
  assign cfg_all = {cfg_lp_read, cfg_cache_rst, cfg_cache_en, cfg_wait,
                    cfg_bus_hold, cfg_pe_mode, cfg_pe_en, cfg_win_lo, cfg_win_hi};

  p_open_needs_key_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr && key_lo == KEY_B));

  p_keywrite_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && key_wr) |=> !unlocked);

  p_locked_cfg_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && g_wr) |=> ($stable(cfg_all) && wp_err));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_err && !(stat_wr && bus_wdata[0])) |=> wp_err);

  p_closed_stays_without_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !key_wr) |=> !unlocked);
endmodule

// File: tb/test_flash_cfg_guard.sv
`timescale 1ns/1ps
module test_flash_cfg_guard;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_we = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        unlocked, wp_err;
  logic [3:0]  cfg_wait;
  logic        cfg_cache_en, cfg_cache_rst, cfg_lp_read, cfg_pe_en, cfg_bus_hold;
  logic [2:0]  cfg_pe_mode;
  logic [19:0] cfg_win_lo, cfg_win_hi;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  flash_cfg_guard i_flash_cfg_guard (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .unlocked(unlocked),
    .wp_err(wp_err), .cfg_wait(cfg_wait), .cfg_cache_en(cfg_cache_en),
    .cfg_cache_rst(cfg_cache_rst), .cfg_lp_read(cfg_lp_read),
    .cfg_pe_en(cfg_pe_en), .cfg_pe_mode(cfg_pe_mode),
    .cfg_bus_hold(cfg_bus_hold), .cfg_win_lo(cfg_win_lo), .cfg_win_hi(cfg_win_hi));

  always #2 clk = ~clk;

  // reference model
  int          m_st;   // 0 idle, 1 pending first key, 2 open
  logic [31:0] m_reg [0:5];
  logic        m_err;

  function automatic logic [31:0] reg_mask(int a);
    case (a)
      1: return 32'h7F;
      2: return 32'h1F;
      3, 4: return 32'hFFFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_reset();
    m_st = 0; m_err = 0;
    for (int i = 0; i < 6; i++) m_reg[i] = 0;
  endfunction

  function automatic void model_write(int a, logic [31:0] d);
    if (a == 0) begin
      if (m_st == 1) m_st = (d[15:0] == 16'h3210) ? 2 : 0;
      else           m_st = (d[15:0] == 16'h0123) ? 1 : 0;
    end else if (a >= 1 && a <= 4) begin
      if (m_st == 2) m_reg[a] = d & reg_mask(a);
      else           m_err = 1;
    end else if (a == 5) begin
      if (d[0]) m_err = 0;
    end
  endfunction

  function automatic logic [31:0] model_read(int a);
    if (a == 0) return {31'b0, m_st == 2};
    if (a == 5) return {31'b0, m_err};
    if (a >= 1 && a <= 4) return m_reg[a];
    return 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a[3:0]; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
    model_write(a, d);
  endtask

  task automatic rd(int a, output logic [31:0] v);
    bus_we = 0; bus_addr = a[3:0];
    #1 v = bus_rdata;
  endtask

  task automatic chk_reg(string req, int a);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, model_read(a));
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 unlocked", {31'b0, unlocked}, 0);
    chk("R1 wp_err", {31'b0, wp_err}, 0);
    for (int a = 1; a <= 4; a++) chk_reg("R1 field", a);

    // R9 guarded write while closed
    wr(1, 32'h7F);
    chk("R9 field unchanged", {25'b0, cfg_lp_read, cfg_cache_rst, cfg_cache_en, cfg_wait}, 0);
    chk("R9 err set", {31'b0, wp_err}, 1);
    // R11 sticky, then clear (status writes allowed while closed)
    wr(5, 32'h0);
    chk("R11 sticky", {31'b0, wp_err}, 1);
    wr(5, 32'h1);
    chk("R11 cleared", {31'b0, wp_err}, 0);

    // R2 unlock, R3 readback
    wr(0, 32'h0123);
    chk("R2 not open after first key", {31'b0, unlocked}, 0);
    wr(0, 32'h3210);
    chk("R2 open", {31'b0, unlocked}, 1);
    rd(0, v); chk("R3 read open", v, 32'h1);

    // R10 / R12 writes while open
    wr(1, 32'hFFFF_FF5A);
    chk("R12 wait", {28'b0, cfg_wait}, 32'hA);
    chk("R12 cache_en", {31'b0, cfg_cache_en}, 1);
    chk("R12 cache_rst", {31'b0, cfg_cache_rst}, 0);
    chk("R12 lp_read", {31'b0, cfg_lp_read}, 1);
    chk_reg("R10 rd readback", 1);
    wr(2, 32'h0000_001B);
    chk("R12 pe_en", {31'b0, cfg_pe_en}, 1);
    chk("R12 pe_mode", {29'b0, cfg_pe_mode}, 32'h5);
    chk("R12 bus_hold", {31'b0, cfg_bus_hold}, 1);
    wr(3, 32'hFFF1_2345); chk("R12 win_lo", {12'b0, cfg_win_lo}, 32'h12345);
    wr(4, 32'h000A_BCDE); chk("R10 win_hi", {12'b0, cfg_win_hi}, 32'hABCDE);
    chk("R10 no err", {31'b0, wp_err}, 0);

    // R4 relock by double second key
    wr(0, 32'h3210);
    chk("R4 closed", {31'b0, unlocked}, 0);
    rd(0, v); chk("R3 read closed", v, 32'h0);
    wr(0, 32'h3210);
    chk("R4 still closed", {31'b0, unlocked}, 0);

    // R5 pending key cleared by other value, including first key
    wr(0, 32'h0123); wr(0, 32'h5555); wr(0, 32'h3210);
    chk("R5 wrong middle", {31'b0, unlocked}, 0);
    wr(0, 32'h0123); wr(0, 32'h0123); wr(0, 32'h3210);
    chk("R5 repeated first key", {31'b0, unlocked}, 0);

    // R7 interleaved writes keep pending key
    wr(0, 32'h0123); wr(3, 32'h1); wr(5, 32'h1); rd(2, v); wr(0, 32'h3210);
    chk("R7 open after interleave", {31'b0, unlocked}, 1);
    chk_reg("R7 window untouched", 3);

    // R6 first key while open closes and re-arms
    wr(0, 32'h0123);
    chk("R6 closed", {31'b0, unlocked}, 0);
    wr(0, 32'h3210);
    chk("R6 reopened", {31'b0, unlocked}, 1);

    // R8 upper bits ignored
    wr(0, 32'h0);
    wr(0, 32'hDEAD_0123); wr(0, 32'hBEEF_3210);
    chk("R8 upper ignored", {31'b0, unlocked}, 1);
    wr(0, 32'h0);
    wr(0, 32'h0001_0123); wr(0, 32'h3211_3211);
    chk("R8 low bits compared", {31'b0, unlocked}, 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int r = $urandom % 12;
      int a;
      logic [31:0] d = $urandom;
      case (r)
        0, 1, 2: wr(0, {d[31:16], 16'h0123});
        3, 4:    wr(0, {d[31:16], 16'h3210});
        5:       wr(0, d);
        6, 7, 8, 9: begin a = 1 + ($urandom % 4); wr(a, d); end
        10:      wr(5, d);
        default: wr(6 + ($urandom % 10), d);
      endcase
      chk_reg("R3 random key read", 0);
      chk("R11 random err", {31'b0, wp_err}, {31'b0, m_err});
      chk_reg("R10 random field", 1 + (i % 4));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule